// File: doc/BRIEF.md
# Bit Count Unit with Word Variants

This unit computes three bit-counting operations on a 64-bit operand, for the execute stage of a 64-bit integer datapath. It can count the zero bits above the highest set bit (leading count), count the zero bits below the lowest set bit (trailing count), or count the set bits (population count). Each operation also has a word form that looks only at the low 32 bits of the operand. The upper half is ignored, and the zero-input result is 32 instead of 64.

Each request is presented for one cycle with `op_valid` high. Its outcome appears one clock later. The outcome is a count zero-extended to 64 bits and an `illegal` flag. The flag is raised in three cases: the bit-manipulation feature is disabled, the reserved operation code is used, or a word form is requested while the core is not in 64-bit mode. When the flag is raised, the result is zero. Register access, decode and hazard handling belong to the surrounding pipeline.

Top module: `bitcount_unit`

## Requirements
- R1: With `op_sel` = 0 (leading) and `word_op` = 0, the result is the number of zero bits above the highest set bit of the 64-bit operand, and 64 when the operand is zero.
- R2: With `op_sel` = 0 and `word_op` = 1, the result is the number of zero bits above the highest set bit within `operand[31:0]`, and 32 when those bits are zero. Bits 63..32 have no effect.
- R3: With `op_sel` = 1 (trailing) and `word_op` = 0, the result is the number of zero bits below the lowest set bit of the operand, and 64 for a zero operand.
- R4: With `op_sel` = 1 and `word_op` = 1, the result is the trailing zero count of `operand[31:0]`, and 32 when those bits are zero. Bits 63..32 have no effect.
- R5: With `op_sel` = 2 (population) and `word_op` = 0, the result is the number of set bits in the 64-bit operand.
- R6: With `op_sel` = 2 and `word_op` = 1, the result is the number of set bits in `operand[31:0]`. The upper half is treated as zero.
- R7: Every result is zero-extended, so bits 63..7 of `result` are always zero.
- R8: When `bitops_en` is 0, the request reports `illegal` = 1 and `result` = 0, whatever the operation.
- R9: `op_sel` = 3 is reserved. It reports `illegal` = 1 and `result` = 0.
- R10: A word form (`word_op` = 1) requested while `wide_mode` = 0 reports `illegal` = 1 and `result` = 0. A full-width form in the same mode is legal.
- R11: `res_valid`, `result` and `illegal` reflect the request from exactly one cycle earlier. A cycle without `op_valid` gives `res_valid` = 0, `illegal` = 0 and `result` = 0. After reset, all three are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Request present this cycle |
| operand | input | 64 | Source operand |
| op_sel | input | 2 | 0 leading, 1 trailing, 2 population, 3 reserved |
| word_op | input | 1 | Operate on the low 32 bits only |
| wide_mode | input | 1 | Core is in 64-bit mode |
| bitops_en | input | 1 | Bit-manipulation feature enable |
| res_valid | output | 1 | Outcome present this cycle |
| result | output | 64 | Zero-extended count |
| illegal | output | 1 | Request was not permitted |

## Verification
In every cycle, the legality gate and the count path both act on the same request. The interesting collision is a disabled, reserved or narrow-mode request whose operand would otherwise give a large count. The bench provokes this by sending all-ones and high-word-only operands with each illegal condition set. It judges the outcome by requiring `illegal` high and a zero result in the following cycle. The same operands, sent through legal requests, are compared against loop-based counts computed in the bench, so the gate is shown to suppress exactly the cases it should.

// File: rtl/bitcount_pkg.sv
package bitcount_pkg;
    localparam int XLEN   = 64;
    localparam int WORD_W = XLEN / 2;
    localparam int CNT_W  = $clog2(XLEN) + 1;

    typedef enum logic [1:0] {
        OP_LEAD  = 2'd0,
        OP_TRAIL = 2'd1,
        OP_POP   = 2'd2,
        OP_RSVD  = 2'd3
    } cnt_op_e;

    typedef struct packed {
        logic             vld;
        logic             ill;
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;
endpackage

// File: rtl/lead_zero_count.sv
module lead_zero_count #(
    parameter int W  = 64,
    localparam int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    // Upward scan: the highest set bit is the last to write.
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) cnt = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/pop_count.sv
module pop_count #(
    parameter int W  = 64,
    localparam int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/count_slice.sv
module count_slice
    import bitcount_pkg::*;
#(
    parameter int W  = 64,
    localparam int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  data,
    input  cnt_op_e       op,
    output logic [CW-1:0] cnt
);
    logic [W-1:0]  rev;
    logic [CW-1:0] lz_cnt;
    logic [CW-1:0] tz_cnt;
    logic [CW-1:0] pc_cnt;

    // Trailing count reuses the leading counter on the mirrored vector.
    for (genvar g = 0; g < W; g++) begin : g_mirror
        assign rev[g] = data[W-1-g];
    end

    lead_zero_count #(.W(W)) u_lead  (.vec(data), .cnt(lz_cnt));
    lead_zero_count #(.W(W)) u_trail (.vec(rev),  .cnt(tz_cnt));
    pop_count       #(.W(W)) u_pop   (.vec(data), .cnt(pc_cnt));

    always_comb begin
        unique case (op)
            OP_LEAD:  cnt = lz_cnt;
            OP_TRAIL: cnt = tz_cnt;
            default:  cnt = pc_cnt;
        endcase
    end
endmodule

// File: rtl/bitcount_unit.sv
module bitcount_unit
    import bitcount_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [XLEN-1:0] operand,
    input  logic [1:0]      op_sel,
    input  logic            word_op,
    input  logic            wide_mode,
    input  logic            bitops_en,
    output logic            res_valid,
    output logic [XLEN-1:0] result,
    output logic            illegal
);
    localparam int WCNT_W = $clog2(WORD_W) + 1;

    cnt_op_e     op;
    logic [CNT_W-1:0]  full_cnt;
    logic [WCNT_W-1:0] word_cnt;
    logic              deny;
    cnt_state_t        st_d, st_q;

    assign op = cnt_op_e'(op_sel);

    count_slice #(.W(XLEN)) u_full (
        .data (operand),
        .op   (op),
        .cnt  (full_cnt)
    );

    count_slice #(.W(WORD_W)) u_word (
        .data (operand[WORD_W-1:0]),
        .op   (op),
        .cnt  (word_cnt)
    );

    assign deny = !bitops_en || (op == OP_RSVD) || (word_op && !wide_mode);

    always_comb begin
        st_d     = '0;
        st_d.vld = op_valid;
        if (op_valid) begin
            st_d.ill = deny;
            if (!deny) begin
                st_d.cnt = word_op ? CNT_W'(word_cnt) : full_cnt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid = st_q.vld;
    assign illegal   = st_q.ill;
    assign result    = {{(XLEN-CNT_W){1'b0}}, st_q.cnt};
endmodule

// File: rtl/bitcount_unit_chk.sv
module bitcount_unit_chk
    import bitcount_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic [XLEN-1:0] operand,
    input logic [1:0]      op_sel,
    input logic            word_op,
    input logic            wide_mode,
    input logic            bitops_en,
    input logic            res_valid,
    input logic [XLEN-1:0] result,
    input logic            illegal
);
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && !illegal && result == '0));
    a_r8_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !bitops_en) |=> (illegal && result == '0));
    a_r9_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 2'd3) |=> (illegal && result == '0));
    a_r10_word_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && word_op && !wide_mode) |=> illegal);
    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        result[XLEN-1:CNT_W] == '0);
    a_r1_zero_full: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && bitops_en && op_sel == 2'd0 && !word_op && operand == '0)
        |=> (result == XLEN'(XLEN) && !illegal));
    a_r2_word_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && bitops_en && wide_mode && word_op && op_sel != 2'd3)
        |=> (result <= XLEN'(WORD_W)));
    a_r6_word_pop_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && bitops_en && wide_mode && word_op && op_sel == 2'd2
         && operand[WORD_W-1:0] == '0) |=> (result == '0 && !illegal));
endmodule

bind bitcount_unit bitcount_unit_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .operand   (operand),
    .op_sel    (op_sel),
    .word_op   (word_op),
    .wide_mode (wide_mode),
    .bitops_en (bitops_en),
    .res_valid (res_valid),
    .result    (result),
    .illegal   (illegal)
);

// File: tb/test_bitcount_unit.sv
module test_bitcount_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [63:0] operand = '0;
    logic [1:0]  op_sel = '0;
    logic        word_op = 1'b0;
    logic        wide_mode = 1'b1;
    logic        bitops_en = 1'b1;
    logic        res_valid;
    logic [63:0] result;
    logic        illegal;

    int checks = 0;
    int failures = 0;
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

    always #10 clk = ~clk;

    bitcount_unit i_bitcount_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .operand   (operand),
        .op_sel    (op_sel),
        .word_op   (word_op),
        .wide_mode (wide_mode),
        .bitops_en (bitops_en),
        .res_valid (res_valid),
        .result    (result),
        .illegal   (illegal)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int ref_lead(input logic [63:0] x, input int w);
        int n = 0;
        bit hit = 0;
        for (int i = w - 1; i >= 0; i--) begin
            if (x[i]) hit = 1;
            else if (!hit) n++;
        end
        return n;
    endfunction

    function automatic int ref_trail(input logic [63:0] x, input int w);
        int n = 0;
        bit hit = 0;
        for (int i = 0; i < w; i++) begin
            if (x[i]) hit = 1;
            else if (!hit) n++;
        end
        return n;
    endfunction

    function automatic int ref_pop(input logic [63:0] x, input int w);
        int n = 0;
        for (int i = 0; i < w; i++) n += int'(x[i]);
        return n;
    endfunction

    task automatic run_op(input logic [63:0] x, input logic [1:0] sel, input logic wrd,
                          input logic wide, input logic en);
        logic  bad;
        int    w;
        int    exp;
        string req;
        @(negedge clk);
        op_valid = 1'b1; operand = x; op_sel = sel; word_op = wrd;
        wide_mode = wide; bitops_en = en;
        @(negedge clk);
        op_valid = 1'b0;
        w = wrd ? 32 : 64;
        bad = !en || sel == 2'd3 || (wrd && !wide);
        if (!en)                req = "R8";
        else if (sel == 2'd3)   req = "R9";
        else if (wrd && !wide)  req = "R10";
        else if (sel == 2'd0)   req = wrd ? "R2" : "R1";
        else if (sel == 2'd1)   req = wrd ? "R4" : "R3";
        else                    req = wrd ? "R6" : "R5";
        if (bad) exp = 0;
        else if (sel == 2'd0) exp = ref_lead(x, w);
        else if (sel == 2'd1) exp = ref_trail(x, w);
        else exp = ref_pop(x, w);
        check(req, result, 64'(exp));
        check({req, " illegal"}, {63'd0, illegal}, {63'd0, bad});
        check("R11 valid", {63'd0, res_valid}, 64'd1);
        check("R7 upper zero", {57'd0, result[63:7]}, 64'd0);
    endtask

    task automatic all_legal(input logic [63:0] x);
        for (int s = 0; s < 3; s++) begin
            for (int wd = 0; wd < 2; wd++) run_op(x, 2'(s), 1'(wd), 1'b1, 1'b1);
        end
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset valid", {63'd0, res_valid}, 64'd0);
        check("R11 reset result", result, 64'd0);
        check("R11 reset illegal", {63'd0, illegal}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 idle valid", {63'd0, res_valid}, 64'd0);

        // R1 R3 R5 zero and all-ones, plus word forms R2 R4 R6
        all_legal(64'd0);
        all_legal({64{1'b1}});
        all_legal(64'hFFFF_FFFF_0000_0000);
        all_legal(64'h0000_0001_0000_0000);
        all_legal(64'h8000_0000_0000_0000);
        for (int b = 0; b < 64; b++) all_legal(64'd1 << b);
        for (int n = 0; n < 250; n++) begin
            seed ^= seed << 13; seed ^= seed >> 7; seed ^= seed << 17;
            all_legal(seed & (seed >> (n % 9)));
        end

        // Illegal gates collide with operands that count high: R8 R9 R10
        for (int s = 0; s < 4; s++) begin
            for (int wd = 0; wd < 2; wd++) begin
                run_op({64{1'b1}}, 2'(s), 1'(wd), 1'b1, 1'b0);
                run_op(64'd0, 2'(s), 1'(wd), 1'b1, 1'b0);
                run_op(64'hFFFF_0000_0000_0000, 2'(s), 1'(wd), 1'b0, 1'b1);
            end
            run_op(64'd0, 2'd3, 1'b0, 1'b1, 1'b1);
        end

        // R11: idle cycle after a request clears the outputs
        @(negedge clk);
        check("R11 idle valid", {63'd0, res_valid}, 64'd0);
        check("R11 idle result", result, 64'd0);
        check("R11 idle illegal", {63'd0, illegal}, 64'd0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule